// File: doc/BRIEF.md
# Instruction Address Breakpoint Unit

This unit watches the address of the instruction that is about to complete and compares it against two breakpoint entries that software programs independently. When an armed entry matches, the unit holds the instruction back from completing in that same cycle. One cycle later it signals either a breakpoint exception or, when the debug side has asked for it, a soft-stop request. For an exception, the unit also supplies the vector address, the saved return address, the saved status word and the new machine-state word for the handler.

A single-step trace request that arrives with the same instruction is arbitrated here. A breakpoint wins and the trace is held off. A trace on its own is granted as a trace exception, or becomes a soft-stop request when soft stop is enabled. Programmed values reach the comparators only when a context-synchronizing instruction is presented. That instruction is itself still compared against the settings that were in force before it, so an entry enabled by the preceding write cannot fire on it, while an entry that the write disabled still fires on it.

Top module: `iab_unit`

## Requirements
- R1: After reset both entries read back as zero (enable bit 1 and qualifier bit 0 cleared), no entry matches, and exc_take, stop_req, trace_take and trace_hold are low.
- R2: When cmpl_valid is high, an active entry matches if its enable bit (bit 1) is set and its address field (bits 31:2) equals cmpl_addr[31:2], with cmpl_addr[1:0] ignored. A match raises cmpl_inhibit in the same cycle. Without soft stop, exc_take pulses in the next cycle with exc_vec = 0x00001300. No match is raised while cmpl_valid is low.
- R3: An entry matches only when its qualifier bit (bit 0) equals the instruction-translation bit, msr_in[5].
- R4: When several entries match, one exception is taken, and exc_src is one-hot on the lowest-numbered matching entry.
- R5: With sstop_en high, a breakpoint match gives stop_req in the next cycle and no exc_take. A trace request with no match also gives stop_req and no trace_take.
- R6: With a trace request and a match in the same cycle, trace_hold is raised and trace_take stays low. A trace request with no match and no soft stop gives trace_take.
- R7: On a breakpoint exception, save_pc equals the full cmpl_addr of the matching instruction, and save_stat is {16'h0, msr_in[15:0]}.
- R8: On a breakpoint exception, msr_new equals msr_in with bits 18, 15, 14, 13, 11, 10, 9, 8, 5, 4 and 1 cleared and bit 0 loaded from bit 16. All other bits are kept.
- R9: A register write reaches the comparators only when an instruction with cmpl_sync high is presented. That instruction, and any instruction before it, is compared against the previous settings.
- R10: cfg_rd_data returns the last word written to the entry chosen by cfg_rd_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for a breakpoint entry |
| cfg_wr_sel | input | IDX_W | Entry selected for the write |
| cfg_wr_data | input | 32 | Entry word: address 31:2, enable 1, qualifier 0 |
| cfg_rd_sel | input | IDX_W | Entry selected for read-back |
| cfg_rd_data | output | 32 | Programmed word of the selected entry |
| cmpl_valid | input | 1 | An instruction is next to complete |
| cmpl_sync | input | 1 | That instruction is context-synchronizing |
| cmpl_addr | input | 32 | Address of the instruction next to complete |
| msr_in | input | 32 | Current machine-state word |
| trace_req | input | 1 | Single-step trace condition for this instruction |
| sstop_en | input | 1 | Soft stop selected by the debug side |
| cmpl_inhibit | output | 1 | Same-cycle hold-back of the matching instruction |
| exc_take | output | 1 | Breakpoint exception taken (pulse) |
| exc_vec | output | 32 | Exception vector address |
| exc_src | output | NUM_BP | One-hot entry that caused the exception |
| save_pc | output | 32 | Saved return address |
| save_stat | output | 32 | Saved status word |
| msr_new | output | 32 | Machine-state word for the handler |
| stop_req | output | 1 | Soft-stop request (pulse) |
| trace_take | output | 1 | Trace exception granted (pulse) |
| trace_hold | output | 1 | Trace deferred behind a breakpoint (pulse) |

## Verification
The bench builds the unit with its default of two entries and the standard vector offset. With this setting, both comparators can match the same address, which exercises the lowest-index rule, and one entry of each qualifier polarity can be armed at once. A one-entry build would reach neither case, and a wider build would only repeat the pairwise case.

// File: rtl/iab_pkg.sv
package iab_pkg;

    localparam int WORD_W = 32;

    // Machine-state bit positions (LSB = 0)
    localparam int MSR_LE   = 0;
    localparam int MSR_RI   = 1;
    localparam int MSR_DR   = 4;
    localparam int MSR_IR   = 5;
    localparam int MSR_FE1  = 8;
    localparam int MSR_BE   = 9;
    localparam int MSR_SE   = 10;
    localparam int MSR_FE0  = 11;
    localparam int MSR_FP   = 13;
    localparam int MSR_PR   = 14;
    localparam int MSR_EE   = 15;
    localparam int MSR_ILE  = 16;
    localparam int MSR_POW  = 18;

    // One breakpoint entry as written by software
    typedef struct packed {
        logic [WORD_W-3:0] addr;
        logic              en;
        logic              tq;
    } bp_entry_t;

    // Proposal produced by the arbiter for one completion slot
    typedef struct packed {
        logic              take;
        logic              stop;
        logic              ttake;
        logic              hold;
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] stat;
        logic [WORD_W-1:0] msr;
    } arb_res_t;

    function automatic logic [WORD_W-1:0] entry_msr(input logic [WORD_W-1:0] cur);
        logic [WORD_W-1:0] m;
        m = cur;
        m[MSR_POW] = 1'b0;
        m[MSR_EE]  = 1'b0;
        m[MSR_PR]  = 1'b0;
        m[MSR_FP]  = 1'b0;
        m[MSR_FE0] = 1'b0;
        m[MSR_SE]  = 1'b0;
        m[MSR_BE]  = 1'b0;
        m[MSR_FE1] = 1'b0;
        m[MSR_IR]  = 1'b0;
        m[MSR_DR]  = 1'b0;
        m[MSR_RI]  = 1'b0;
        m[MSR_LE]  = cur[MSR_ILE];
        return m;
    endfunction

endpackage

// File: rtl/iab_regs.sv
module iab_regs
    import iab_pkg::*;
#(
    parameter int NUM_BP = 2,
    parameter int IDX_W  = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_sel,
    input  logic [WORD_W-1:0]         wr_data,
    input  logic                      sync_pulse,
    input  logic [IDX_W-1:0]          rd_sel,
    output logic [WORD_W-1:0]         rd_data,
    output bp_entry_t [NUM_BP-1:0]    act_o
);

    typedef struct packed {
        bp_entry_t [NUM_BP-1:0] prog;
        bp_entry_t [NUM_BP-1:0] act;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        // Live copy takes the programmed values when a synchronizing
        // instruction is presented; a same-cycle write waits for the next.
        if (sync_pulse) begin
            bank_d.act = bank_q.prog;
        end
        if (wr_en && (int'(wr_sel) < NUM_BP)) begin
            bank_d.prog[wr_sel] = bp_entry_t'(wr_data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_sel) < NUM_BP) begin
            rd_data = WORD_W'(bank_q.prog[rd_sel]);
        end
    end

    assign act_o = bank_q.act;

endmodule

// File: rtl/iab_cmp.sv
module iab_cmp
    import iab_pkg::*;
(
    input  bp_entry_t         entry,
    input  logic              valid,
    input  logic [WORD_W-3:0] word_addr,
    input  logic              xlat,
    output logic              hit
);

    always_comb begin
        hit = valid && entry.en && (entry.tq == xlat) && (entry.addr == word_addr);
    end

endmodule

// File: rtl/iab_arb.sv
module iab_arb
    import iab_pkg::*;
#(
    parameter int NUM_BP = 2
) (
    input  logic [NUM_BP-1:0] hit_vec,
    input  logic              valid,
    input  logic              trace_req,
    input  logic              sstop_en,
    input  logic [WORD_W-1:0] cmpl_addr,
    input  logic [WORD_W-1:0] msr_in,
    output logic [NUM_BP-1:0] src_oh,
    output arb_res_t          res
);

    logic any_hit;
    logic trc;

    always_comb begin
        any_hit = |hit_vec;
        trc     = valid && trace_req;
        // Lowest-numbered matching entry wins
        src_oh  = hit_vec & (~hit_vec + NUM_BP'(1));

        res       = '0;
        res.take  = any_hit && !sstop_en;
        res.stop  = sstop_en && (any_hit || trc);
        res.ttake = trc && !any_hit && !sstop_en;
        res.hold  = trc && any_hit;
        res.pc    = cmpl_addr;
        res.stat  = {16'h0000, msr_in[15:0]};
        res.msr   = entry_msr(msr_in);
    end

endmodule

// File: rtl/iab_unit.sv
module iab_unit
    import iab_pkg::*;
#(
    parameter int          NUM_BP     = 2,
    parameter logic [31:0] VEC_OFFSET = 32'h0000_1300,
    localparam int         IDX_W      = (NUM_BP > 1) ? $clog2(NUM_BP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [IDX_W-1:0]  cfg_wr_sel,
    input  logic [31:0]       cfg_wr_data,
    input  logic [IDX_W-1:0]  cfg_rd_sel,
    output logic [31:0]       cfg_rd_data,
    input  logic              cmpl_valid,
    input  logic              cmpl_sync,
    input  logic [31:0]       cmpl_addr,
    input  logic [31:0]       msr_in,
    input  logic              trace_req,
    input  logic              sstop_en,
    output logic              cmpl_inhibit,
    output logic              exc_take,
    output logic [31:0]       exc_vec,
    output logic [NUM_BP-1:0] exc_src,
    output logic [31:0]       save_pc,
    output logic [31:0]       save_stat,
    output logic [31:0]       msr_new,
    output logic              stop_req,
    output logic              trace_take,
    output logic              trace_hold
);

    typedef struct packed {
        logic              take;
        logic              stop;
        logic              ttake;
        logic              hold;
        logic [NUM_BP-1:0] src;
        logic [31:0]       vec;
        logic [31:0]       pc;
        logic [31:0]       stat;
        logic [31:0]       msr;
    } out_t;

    bp_entry_t [NUM_BP-1:0] act;
    logic [NUM_BP-1:0]      hit_vec;
    logic [NUM_BP-1:0]      src_oh;
    arb_res_t               prop;
    out_t                   out_d, out_q;

    iab_regs #(.NUM_BP(NUM_BP), .IDX_W(IDX_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wr_sel     (cfg_wr_sel),
        .wr_data    (cfg_wr_data),
        .sync_pulse (cmpl_valid && cmpl_sync),
        .rd_sel     (cfg_rd_sel),
        .rd_data    (cfg_rd_data),
        .act_o      (act)
    );

    for (genvar g = 0; g < NUM_BP; g++) begin : g_cmp
        iab_cmp u_cmp (
            .entry     (act[g]),
            .valid     (cmpl_valid),
            .word_addr (cmpl_addr[31:2]),
            .xlat      (msr_in[MSR_IR]),
            .hit       (hit_vec[g])
        );
    end

    iab_arb #(.NUM_BP(NUM_BP)) u_arb (
        .hit_vec   (hit_vec),
        .valid     (cmpl_valid),
        .trace_req (trace_req),
        .sstop_en  (sstop_en),
        .cmpl_addr (cmpl_addr),
        .msr_in    (msr_in),
        .src_oh    (src_oh),
        .res       (prop)
    );

    always_comb begin
        out_d       = out_q;
        out_d.take  = prop.take;
        out_d.stop  = prop.stop;
        out_d.ttake = prop.ttake;
        out_d.hold  = prop.hold;
        out_d.src   = prop.take ? src_oh : '0;
        if (prop.take) begin
            out_d.vec  = VEC_OFFSET;
            out_d.pc   = prop.pc;
            out_d.stat = prop.stat;
            out_d.msr  = prop.msr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign cmpl_inhibit = |hit_vec;
    assign exc_take     = out_q.take;
    assign stop_req     = out_q.stop;
    assign trace_take   = out_q.ttake;
    assign trace_hold   = out_q.hold;
    assign exc_src      = out_q.src;
    assign exc_vec      = out_q.vec;
    assign save_pc      = out_q.pc;
    assign save_stat    = out_q.stat;
    assign msr_new      = out_q.msr;

endmodule

// File: rtl/iab_unit_chk.sv
module iab_unit_chk #(
    parameter int NUM_BP = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmpl_valid,
    input logic [31:0]       cmpl_addr,
    input logic [31:0]       msr_in,
    input logic              sstop_en,
    input logic              cmpl_inhibit,
    input logic              exc_take,
    input logic [31:0]       exc_vec,
    input logic [NUM_BP-1:0] exc_src,
    input logic [31:0]       save_pc,
    input logic [31:0]       save_stat,
    input logic [31:0]       msr_new,
    input logic              stop_req,
    input logic              trace_take,
    input logic              trace_hold
);

    assert_inhibit_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_inhibit |-> cmpl_valid);

    assert_hit_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_inhibit && !sstop_en) |=> (exc_take && exc_vec == 32'h0000_1300));

    assert_one_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |-> ($countones(exc_src) == 1));

    assert_stop_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |-> (!exc_take && !trace_take));

    assert_hold_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trace_hold |-> !trace_take);

    assert_saved_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |-> (save_pc == $past(cmpl_addr) && save_stat[31:16] == 16'h0));

    assert_msr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_take |-> (msr_new[0] == $past(msr_in[16]) && msr_new[15:13] == 3'b000
                      && msr_new[12] == $past(msr_in[12])));

endmodule

bind iab_unit iab_unit_chk #(.NUM_BP(NUM_BP)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmpl_valid   (cmpl_valid),
    .cmpl_addr    (cmpl_addr),
    .msr_in       (msr_in),
    .sstop_en     (sstop_en),
    .cmpl_inhibit (cmpl_inhibit),
    .exc_take     (exc_take),
    .exc_vec      (exc_vec),
    .exc_src      (exc_src),
    .save_pc      (save_pc),
    .save_stat    (save_stat),
    .msr_new      (msr_new),
    .stop_req     (stop_req),
    .trace_take   (trace_take),
    .trace_hold   (trace_hold)
);

// File: tb/iab_unit_tb.sv
`timescale 1ns/1ps
module iab_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [0:0]  cfg_wr_sel = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [0:0]  cfg_rd_sel = '0;
    logic [31:0] cfg_rd_data;
    logic        cmpl_valid = 1'b0;
    logic        cmpl_sync = 1'b0;
    logic [31:0] cmpl_addr = '0;
    logic [31:0] msr_in = '0;
    logic        trace_req = 1'b0;
    logic        sstop_en = 1'b0;
    logic        cmpl_inhibit, exc_take, stop_req, trace_take, trace_hold;
    logic [31:0] exc_vec, save_pc, save_stat, msr_new;
    logic [1:0]  exc_src;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic inh_s;

    always #2.5 clk = ~clk;

    iab_unit u_dut (.*);

    localparam logic [31:0] MSR_A = 32'h0001_9032; // bit 5 (translation) = 1
    localparam logic [31:0] MSR_B = 32'h0000_C013; // bit 5 (translation) = 0

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] msr;
        logic        trc;
        logic        ss;
        logic        inh;
        logic        take;
        logic        stop;
        logic        ttake;
        logic        hold;
        logic [1:0]  src;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{32'h0000_4000, MSR_B, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01},
        '{32'h0000_4000, MSR_A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00},
        '{32'h0000_8000, MSR_A, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10},
        '{32'h0000_8000, MSR_B, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00},
        '{32'h0000_4000, MSR_B, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'b01},
        '{32'h1234_0000, MSR_B, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00},
        '{32'h0000_4000, MSR_B, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00},
        '{32'h0000_2000, MSR_B, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00},
        '{32'h0000_4004, MSR_B, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'b00},
        '{32'h0000_4002, MSR_B, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'b01}
    };

    function automatic logic [31:0] exp_msr(input logic [31:0] m);
        logic [31:0] r;
        r = m;
        foreach (r[i]) begin
            if (i == 18 || i == 15 || i == 14 || i == 13 || i == 11 || i == 10 ||
                i == 9 || i == 8 || i == 5 || i == 4 || i == 1) r[i] = 1'b0;
        end
        r[0] = m[16];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_wr_sel = sel[0:0];
        cfg_wr_data = data;
        @(posedge clk);
        #1 cfg_wr_en = 1'b0;
    endtask

    // Present one instruction: sample inhibit before the edge,
    // registered outputs just after it.
    task automatic issue(input logic [31:0] a, input logic [31:0] m,
                         input logic t, input logic s, input logic sy);
        @(negedge clk);
        cmpl_valid = 1'b1;
        cmpl_addr = a;
        msr_in = m;
        trace_req = t;
        sstop_en = s;
        cmpl_sync = sy;
        #1 inh_s = cmpl_inhibit;
        @(posedge clk);
        #1;
        cmpl_valid = 1'b0;
        cmpl_sync = 1'b0;
        trace_req = 1'b0;
        sstop_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 state during and after reset
        check("R1 exc_take", {31'b0, exc_take}, 32'h0);
        check("R1 stop_req", {31'b0, stop_req}, 32'h0);
        rst_n = 1'b1;
        cfg_rd_sel = 1'b0;
        #1 check("R1 entry0", cfg_rd_data, 32'h0);
        cfg_rd_sel = 1'b1;
        #1 check("R1 entry1", cfg_rd_data, 32'h0);
        issue(32'h0000_0000, MSR_B, 1'b0, 1'b0, 1'b1);
        check("R1 no match after reset", {31'b0, inh_s}, 32'h0);
        check("R1 no take after reset", {31'b0, exc_take}, 32'h0);

        // Program: entry0 0x4000 enabled, qualifier 0; entry1 0x8000 enabled, qualifier 1
        wr(0, 32'h0000_4002);
        wr(1, 32'h0000_8003);
        cfg_rd_sel = 1'b0;
        #1 check("R10 readback entry0", cfg_rd_data, 32'h0000_4002);
        cfg_rd_sel = 1'b1;
        #1 check("R10 readback entry1", cfg_rd_data, 32'h0000_8003);
        // R9 before any sync the written entries are not live
        issue(32'h0000_4000, MSR_B, 1'b0, 1'b0, 1'b0);
        check("R9 pending write not live", {31'b0, inh_s}, 32'h0);
        issue(32'h0000_0100, MSR_B, 1'b0, 1'b0, 1'b1);

        // Table walk: R2 R3 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            issue(TBL[i].addr, TBL[i].msr, TBL[i].trc, TBL[i].ss, 1'b0);
            check($sformatf("R2 inhibit v%0d", i), {31'b0, inh_s}, {31'b0, TBL[i].inh});
            check($sformatf("R2 take v%0d", i), {31'b0, exc_take}, {31'b0, TBL[i].take});
            check($sformatf("R5 stop v%0d", i), {31'b0, stop_req}, {31'b0, TBL[i].stop});
            check($sformatf("R6 trace_take v%0d", i), {31'b0, trace_take}, {31'b0, TBL[i].ttake});
            check($sformatf("R6 trace_hold v%0d", i), {31'b0, trace_hold}, {31'b0, TBL[i].hold});
            check($sformatf("R4 src v%0d", i), {30'b0, exc_src}, {30'b0, TBL[i].src});
            if (TBL[i].take) begin
                check($sformatf("R2 vector v%0d", i), exc_vec, 32'h0000_1300);
                check($sformatf("R7 save_pc v%0d", i), save_pc, TBL[i].addr);
                check($sformatf("R7 save_stat v%0d", i), save_stat, {16'h0, TBL[i].msr[15:0]});
                check($sformatf("R8 msr_new v%0d", i), msr_new, exp_msr(TBL[i].msr));
            end
        end

        // R2 no match without a valid instruction
        @(negedge clk);
        cmpl_addr = 32'h0000_4000;
        msr_in = MSR_B;
        #1 check("R2 invalid no inhibit", {31'b0, cmpl_inhibit}, 32'h0);

        // R4 both entries on the same address: one exception, lowest entry
        wr(1, 32'h0000_4002);
        issue(32'h0000_0200, MSR_B, 1'b0, 1'b0, 1'b1);
        issue(32'h0000_4000, MSR_B, 1'b0, 1'b0, 1'b0);
        check("R4 single take", {31'b0, exc_take}, 32'h1);
        check("R4 lowest source", {30'b0, exc_src}, 32'h1);

        // R9 disabling write: still fires before and on the sync instruction
        wr(0, 32'h0000_4000);
        wr(1, 32'h0000_0000);
        issue(32'h0000_4000, MSR_B, 1'b0, 1'b0, 1'b0);
        check("R9 disabled still live before sync", {31'b0, inh_s}, 32'h1);
        issue(32'h0000_4000, MSR_B, 1'b0, 1'b0, 1'b1);
        check("R9 disabled fires on sync", {31'b0, inh_s}, 32'h1);
        issue(32'h0000_4000, MSR_B, 1'b0, 1'b0, 1'b0);
        check("R9 disabled after sync", {31'b0, inh_s}, 32'h0);

        // R9 enabling write: no fire on the sync instruction, fires after
        wr(0, 32'h0000_4002);
        issue(32'h0000_4000, MSR_B, 1'b0, 1'b0, 1'b1);
        check("R9 enabled silent on sync", {31'b0, inh_s}, 32'h0);
        issue(32'h0000_4000, MSR_B, 1'b0, 1'b0, 1'b0);
        check("R9 enabled fires after sync", {31'b0, inh_s}, 32'h1);
        check("R9 enabled take", {31'b0, exc_take}, 32'h1);

        // R1 reset clears the programmed enables
        @(negedge clk);
        rst_n = 1'b0;
        #1 cfg_rd_sel = 1'b0;
        #1 check("R1 reset clears entry0", cfg_rd_data, 32'h0);
        check("R1 reset clears take", {31'b0, exc_take}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        issue(32'h0000_4000, MSR_B, 1'b0, 1'b0, 1'b1);
        check("R1 no match after second reset", {31'b0, inh_s}, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule